// File: doc/BRIEF.md
# Receive Loss-of-Signal / Loss-of-Clock Persistence Monitor

This block produces one qualified loss status bit for a receive line. A configuration input chooses its source. In clock mode the bit reports whether the recovered receive clock is still running. A free-running reference clock judges this. In signal mode the bit reports that a raw loss-of-signal flag has stayed active without a break for a fixed persistence interval, normally 1 ms. The raw flag comes from an upstream zero-run detector. That detector raises it after 100 zeros in a row, once the line interface has squelched a weak input to all zeros.

Clock presence is sensed by a flop that toggles on every receive clock edge. Its output is synchronised into the reference domain, and each change counts as activity. If no activity is seen for `ABSENT_CYCLES` reference cycles, the clock is taken as absent. The persistence interval is `PERSIST_CYCLES` reference cycles. The raw flag and the select input are sampled synchronously to the reference clock. The receive clock must run at less than half the reference frequency so that every toggle is seen.

Top module: `los_persist_mon`

## Requirements
- R1: While reset is active, and on the first reference edges after it is released, `lossOut` is 0.
- R2: With `modeSel` = 0 (clock mode) and the receive clock toggling at less than half the reference rate, `lossOut` stays 0.
- R3: In clock mode, `lossOut` becomes 1 once the receive clock has stopped for `ABSENT_CYCLES` reference cycles plus the synchroniser latency. It does not become 1 before `ABSENT_CYCLES` minus 3 cycles have passed.
- R4: In clock mode, `lossOut` returns to 0 within 8 reference cycles after the receive clock restarts.
- R5: With `modeSel` = 1 (signal mode), `lossOut` becomes 1 on the `PERSIST_CYCLES`-th consecutive reference edge that samples `rawLos` = 1, and not on any earlier edge.
- R6: In signal mode, `lossOut` goes to 0 on the first edge that samples `rawLos` = 0. A later assertion of `rawLos` must again persist for a full `PERSIST_CYCLES` edges.
- R7: In signal mode, the state of the receive clock has no effect on `lossOut`.
- R8: An edge that samples `modeSel` different from the previous edge clears `lossOut` to 0 and restarts the persistence timer from zero. This clearing takes priority over a timer completing on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxClk | input | 1 | Monitored receive clock (may stop) |
| rawLos | input | 1 | Raw loss-of-signal flag, synchronous to refClk |
| modeSel | input | 1 | 0 = report clock absence, 1 = report persisted signal loss |
| lossOut | output | 1 | Qualified loss status |

## Verification
The persistence timer can complete on the same edge that samples a new value of `modeSel`. The clearing on a mode change must win. The bench raises `rawLos` in signal mode and flips `modeSel` so that the change is sampled on exactly the edge where `lossOut` would otherwise rise. It expects 0 on that edge. It then switches back and expects the rise only after a full fresh interval counted from the second change. An early rise would show a stale count, and a one-cycle pulse of 1 would show the wrong priority.

// File: rtl/los_mon_pkg.sv
package los_mon_pkg;

  typedef enum logic {
    MODE_CLOCK  = 1'b0,
    MODE_SIGNAL = 1'b1
  } monMode_e;

  typedef struct packed {
    logic clrTimer;
    logic clrActivity;
  } monStrobe_t;

endpackage

// File: rtl/los_toggle_sync.sv
module los_toggle_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic rxClk,
  output logic edgeSeen
);

  logic rxToggle;
  logic [SYNC_STAGES-1:0] syncChain;
  logic syncPrev;

  always_ff @(posedge rxClk or negedge rstN) begin
    if (!rstN) rxToggle <= 1'b0;
    else       rxToggle <= ~rxToggle;
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge refClk or negedge rstN) begin
        if (!rstN) syncChain[0] <= 1'b0;
        else       syncChain[0] <= rxToggle;
      end
    end else begin : g_next
      always_ff @(posedge refClk or negedge rstN) begin
        if (!rstN) syncChain[s] <= 1'b0;
        else       syncChain[s] <= syncChain[s-1];
      end
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= syncChain[SYNC_STAGES-1];
  end

  assign edgeSeen = syncChain[SYNC_STAGES-1] ^ syncPrev;

endmodule

// File: rtl/los_mon_datapath.sv
module los_mon_datapath
  import los_mon_pkg::*;
#(
  parameter int PERSIST_CYCLES = 100000,
  parameter int ABSENT_CYCLES  = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       rxClk,
  input  logic       rawLos,
  input  monStrobe_t strobe,
  output logic       clkAbsent,
  output logic       persistReady
);

  localparam int PW = $clog2(PERSIST_CYCLES + 1);
  localparam int AW = $clog2(ABSENT_CYCLES + 1);
  localparam logic [PW-1:0] PERSIST_MAX  = PW'(PERSIST_CYCLES);
  localparam logic [PW-1:0] PERSIST_NEAR = PW'(PERSIST_CYCLES - 1);
  localparam logic [AW-1:0] ABSENT_MAX   = AW'(ABSENT_CYCLES);

  logic          edgeSeen;
  logic [PW-1:0] persistCnt;
  logic [AW-1:0] idleCnt;

  los_toggle_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .refClk  (refClk),
    .rstN    (rstN),
    .rxClk   (rxClk),
    .edgeSeen(edgeSeen)
  );

  // reference cycles since the last observed receive clock activity
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                                idleCnt <= '0;
    else if (strobe.clrActivity || edgeSeen)  idleCnt <= '0;
    else if (idleCnt != ABSENT_MAX)           idleCnt <= idleCnt + 1'b1;
  end

  // consecutive sampled cycles of raw loss
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                              persistCnt <= '0;
    else if (strobe.clrTimer || !rawLos)    persistCnt <= '0;
    else if (persistCnt != PERSIST_MAX)     persistCnt <= persistCnt + 1'b1;
  end

  assign clkAbsent    = (idleCnt == ABSENT_MAX);
  assign persistReady = (persistCnt >= PERSIST_NEAR);

endmodule

// File: rtl/los_mon_ctrl.sv
module los_mon_ctrl
  import los_mon_pkg::*;
(
  input  logic       refClk,
  input  logic       rstN,
  input  logic       modeSel,
  input  logic       rawLos,
  input  logic       clkAbsent,
  input  logic       persistReady,
  output monStrobe_t strobe,
  output logic       lossOut
);

  monMode_e modeNow;
  monMode_e modePrev;
  logic     modeChange;
  logic     lossNext;

  assign modeNow    = monMode_e'(modeSel);
  assign modeChange = (modeNow != modePrev);

  always_comb begin
    strobe.clrTimer    = modeChange;
    strobe.clrActivity = modeChange;
  end

  always_comb begin
    if (modeChange)                    lossNext = 1'b0;
    else if (modeNow == MODE_SIGNAL)   lossNext = rawLos && persistReady;
    else                               lossNext = clkAbsent;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      modePrev <= MODE_CLOCK;
      lossOut  <= 1'b0;
    end else begin
      modePrev <= modeNow;
      lossOut  <= lossNext;
    end
  end

endmodule

// File: rtl/los_persist_mon.sv
module los_persist_mon
  import los_mon_pkg::*;
#(
  parameter int PERSIST_CYCLES = 100000,
  parameter int ABSENT_CYCLES  = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic rxClk,
  input  logic rawLos,
  input  logic modeSel,
  output logic lossOut
);

  monStrobe_t strobe;
  logic       clkAbsent;
  logic       persistReady;

  los_mon_datapath #(
    .PERSIST_CYCLES(PERSIST_CYCLES),
    .ABSENT_CYCLES (ABSENT_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_dp (
    .refClk      (refClk),
    .rstN        (rstN),
    .rxClk       (rxClk),
    .rawLos      (rawLos),
    .strobe      (strobe),
    .clkAbsent   (clkAbsent),
    .persistReady(persistReady)
  );

  los_mon_ctrl u_ctrl (
    .refClk      (refClk),
    .rstN        (rstN),
    .modeSel     (modeSel),
    .rawLos      (rawLos),
    .clkAbsent   (clkAbsent),
    .persistReady(persistReady),
    .strobe      (strobe),
    .lossOut     (lossOut)
  );

endmodule

// File: rtl/los_mon_checker.sv
module los_mon_checker (
  input logic refClk,
  input logic rstN,
  input logic rawLos,
  input logic modeSel,
  input logic lossOut
);

  AST_SIGNAL_DROP: assert property (@(posedge refClk) disable iff (!rstN)
    (modeSel && !rawLos) |=> !lossOut); // R6

  AST_MODE_CLEAR: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(rstN) && (modeSel != $past(modeSel))) |=> !lossOut); // R8

  AST_SIGNAL_HOLD: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(rstN) && $past(modeSel) && lossOut) |-> $past(rawLos)); // R5

  AST_SIGNAL_RISE: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(rstN) && modeSel && $past(modeSel) && $rose(lossOut)) |-> $past(rawLos, 2)); // R5

  always_comb begin
    if (!rstN) begin
      AST_RESET_LOW: assert (!lossOut); // R1
    end
  end

endmodule

bind los_persist_mon los_mon_checker u_chk (
  .refClk (refClk),
  .rstN   (rstN),
  .rawLos (rawLos),
  .modeSel(modeSel),
  .lossOut(lossOut)
);

// File: tb/los_persist_mon_bench.sv
module los_persist_mon_bench;

  localparam int P = 40;
  localparam int A = 16;

  typedef struct {
    int    cyc;
    logic  val;
    string tag;
  } expItem_t;

  logic refClk = 1'b0;
  logic rstN   = 1'b0;
  logic rxClk  = 1'b0;
  logic rawLos = 1'b0;
  logic modeSel = 1'b0;
  logic rxRun  = 1'b1;
  logic lossOut;

  int edgeCnt = 0;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  los_persist_mon #(
    .PERSIST_CYCLES(P),
    .ABSENT_CYCLES (A),
    .SYNC_STAGES   (2)
  ) u_los_persist_mon (
    .refClk (refClk),
    .rstN   (rstN),
    .rxClk  (rxClk),
    .rawLos (rawLos),
    .modeSel(modeSel),
    .lossOut(lossOut)
  );

  always #5 refClk = ~refClk;

  always begin
    if (rxRun) begin
      rxClk = 1'b1; #15;
      rxClk = 1'b0; #15;
    end else begin
      #5;
    end
  end

  always @(posedge refClk) edgeCnt <= edgeCnt + 1;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge refClk);
    #1;
  endtask

  task automatic expectAt(input int cyc, input logic val, input string tag);
    expItem_t it;
    it.cyc = cyc;
    it.val = val;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1'b1;
    $finish;
  endtask

  // monitor: compares the scoreboard against the output between edges
  always @(negedge refClk) begin
    while (expQ.size() > 0 && expQ[0].cyc <= edgeCnt) begin
      expItem_t it;
      it = expQ.pop_front();
      total++;
      if (it.cyc != edgeCnt) begin
        bad++;
        $display("FAIL %s: expectation for edge %0d missed (now %0d)", it.tag, it.cyc, edgeCnt);
      end else if (lossOut !== it.val) begin
        bad++;
        $display("FAIL %s: edge %0d lossOut=%b expected %b", it.tag, edgeCnt, lossOut, it.val);
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge refClk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual edge %0d expected end before 50000", edgeCnt);
      finishRun();
    end
  end

  initial begin
    int n;
    int m;
    // R1: reset state
    step(4);
    total++;
    if (lossOut !== 1'b0) begin
      bad++;
      $display("FAIL R1: lossOut=%b during reset expected 0", lossOut);
    end
    rstN = 1'b1;
    expectAt(edgeCnt + 1, 1'b0, "R1");
    expectAt(edgeCnt + 3, 1'b0, "R1");
    step(10);

    // R2: clock mode, receive clock running
    n = edgeCnt;
    expectAt(n + 20, 1'b0, "R2");
    expectAt(n + 40, 1'b0, "R2");
    expectAt(n + 60, 1'b0, "R2");
    step(62);

    // R3: receive clock stops
    rxRun = 1'b0;
    n = edgeCnt;
    expectAt(n + A - 3, 1'b0, "R3");
    expectAt(n + A + 10, 1'b1, "R3");
    step(A + 12);

    // R4: receive clock restarts
    rxRun = 1'b1;
    m = edgeCnt;
    expectAt(m + 8, 1'b0, "R4");
    expectAt(m + 20, 1'b0, "R4");
    step(22);

    // R8: switch to signal mode, output cleared
    modeSel = 1'b1;
    n = edgeCnt;
    expectAt(n + 1, 1'b0, "R8");
    step(5);

    // R5: persistence interval
    rawLos = 1'b1;
    n = edgeCnt;
    expectAt(n + P - 1, 1'b0, "R5");
    expectAt(n + P, 1'b1, "R5");
    expectAt(n + P + 5, 1'b1, "R5");
    step(P + 6);

    // R6: immediate drop, then restart after a short break
    rawLos = 1'b0;
    n = edgeCnt;
    expectAt(n + 1, 1'b0, "R6");
    step(2);
    rawLos = 1'b1;
    step(P - 5);
    rawLos = 1'b0;
    step(1);
    rawLos = 1'b1;
    n = edgeCnt;
    expectAt(n + P - 1, 1'b0, "R6");
    expectAt(n + P, 1'b1, "R6");
    step(P + 2);
    rawLos = 1'b0;
    step(2);

    // R7: signal mode ignores the receive clock
    rxRun = 1'b0;
    n = edgeCnt;
    expectAt(n + A + 10, 1'b0, "R7");
    expectAt(n + A + 20, 1'b0, "R7");
    step(A + 22);
    rawLos = 1'b1;
    n = edgeCnt;
    expectAt(n + P, 1'b1, "R7");
    step(P + 2);
    rawLos = 1'b0;
    rxRun = 1'b1;
    step(10);

    // R8: mode change on the edge where the timer would complete
    rawLos = 1'b1;
    n = edgeCnt;
    step(P - 1);
    modeSel = 1'b0;
    expectAt(n + P, 1'b0, "R8");
    expectAt(n + P + 3, 1'b0, "R8");
    step(6);
    modeSel = 1'b1;
    m = edgeCnt;
    expectAt(m + P, 1'b0, "R8");
    expectAt(m + P + 1, 1'b1, "R8");
    step(P + 4);

    while (expQ.size() > 0) step(1);
    step(2);
    finishRun();
  end

endmodule